// File: doc/BRIEF.md
# Host Packet FIFO Port

This block is the host-facing port of a packet switch. It holds two independent first-in first-out buffers that share one clock. On the outbound path the host writes packet characters with an active-low push strobe, and the switch fabric drains them through a valid/ready pair. On the inbound path the fabric delivers characters through a valid/ready pair, and the host reads them with an active-low pop strobe. The inbound buffer shows its oldest entry on the read data port as soon as that entry is stored, so the host can inspect a character before it commits a pop.

Each stored word is 9 bits. Bits 7:0 carry a data byte, and bit 8 marks a packet-end character. Two packet-end codes are defined: 0x100 ends a packet normally, and 0x101 ends a packet that was corrupted. The block does not interpret these codes. It carries every 9-bit value through unchanged, in order. The host sees a full flag and an almost-full flag on the outbound side, and an empty flag and an almost-empty flag on the inbound side. The almost thresholds are fixed by a parameter. The fabric's valid and ready signals are driven straight from the empty and full state of each buffer.

Top module: `hostport_fifo_pair`

## Requirements
- R1: After a synchronous reset both buffers hold nothing. The host sees host_tx_full=0, host_tx_afull=0, host_rx_empty=1 and host_rx_aempty=1. The fabric sees rtr_tx_valid=0 and rtr_rx_ready=1.
- R2: A host write is taken only on a rising clock edge where host_tx_push_n is 0. With host_tx_push_n at 1, nothing is stored, whatever is on host_tx_data.
- R3: Each path returns words in the order they were accepted, with all 9 bits intact. This includes the packet-end codes 0x100 and 0x101 and data words whose bit 8 is 0.
- R4: The inbound path is fall-through. One edge after a fabric handshake into an empty buffer, host_rx_empty is 0 and host_rx_data already equals the stored word, with no pop.
- R5: A host read is taken only on a rising edge where host_rx_pop_n is 0 and host_rx_empty is 0. host_rx_data then moves to the next stored word.
- R6: With 128 entries, host_tx_full is 1 exactly when 128 words are stored, and rtr_rx_ready is 0 exactly in the same condition on the inbound side. host_tx_afull is 1 exactly when 8 or fewer entries are free, that is 120 or more words stored.
- R7: host_rx_empty is 1 exactly when no word is stored. host_rx_aempty is 1 exactly when 8 or fewer words are stored.
- R8: A write attempt while a buffer is full is dropped. The stored contents and their order stay as they were.
- R9: A read attempt while a buffer is empty is dropped. The next word written becomes the head.
- R10: A write and a read in the same cycle, on a buffer that is neither empty nor full, leave the stored word count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| host_tx_data | input | 9 | Outbound word from host |
| host_tx_push_n | input | 1 | Outbound write strobe, active low |
| host_tx_full | output | 1 | Outbound buffer full |
| host_tx_afull | output | 1 | Outbound buffer has 8 or fewer free entries |
| rtr_tx_data | output | 9 | Outbound head word to fabric |
| rtr_tx_valid | output | 1 | Outbound head word present |
| rtr_tx_ready | input | 1 | Fabric takes outbound head word |
| rtr_rx_data | input | 9 | Inbound word from fabric |
| rtr_rx_valid | input | 1 | Fabric offers inbound word |
| rtr_rx_ready | output | 1 | Inbound buffer can accept a word |
| host_rx_data | output | 9 | Inbound head word, visible before pop |
| host_rx_pop_n | input | 1 | Inbound read strobe, active low |
| host_rx_empty | output | 1 | Inbound buffer empty |
| host_rx_aempty | output | 1 | Inbound buffer holds 8 or fewer words |

## Verification
If the occupancy count drifts, a flag goes wrong within one edge of the bad update. The error shows at the threshold crossings at 120, 128, 8 and 0 words. It also shows as an extra or missing word when a buffer is drained. A wrong read or write pointer shows as a wrong head word on the very next handshake. A dropped-write bug at full would corrupt the order of the data drained afterwards, so every fill is followed by a complete drain that is checked word by word.

// File: rtl/hpf_pkg.sv
package hpf_pkg;

    localparam int HPF_WORD_W  = 9;
    localparam int HPF_DEPTH   = 128;
    localparam int HPF_MARGIN  = 8;

    typedef struct packed {
        logic       mark;
        logic [7:0] payload;
    } hpf_word_t;

    localparam hpf_word_t HPF_END_OK  = '{mark: 1'b1, payload: 8'h00};
    localparam hpf_word_t HPF_END_ERR = '{mark: 1'b1, payload: 8'h01};

    function automatic logic hpf_is_end(input hpf_word_t w);
        return w.mark;
    endfunction

endpackage

// File: rtl/hpf_fifo_core.sv
module hpf_fifo_core #(
    parameter int W     = 9,
    parameter int DEPTH = 128,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_req,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_go, rd_go;

    assign full    = (count == CNT_MAX);
    assign empty   = (count == '0);
    assign wr_go   = wr_req && !full;
    assign rd_go   = rd_req && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_go) wr_ptr <= ptr_next(wr_ptr);
            if (rd_go) rd_ptr <= ptr_next(rd_ptr);
            case ({wr_go, rd_go})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_MAX);
    assert_full_push_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full && !rd_req) |=> (count == CNT_MAX));
    assert_empty_pop_dropped_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !wr_req) |=> (count == '0));
    assert_both_keep_count_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && !full && !empty) |=> $stable(count));
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !empty) |=> (rd_ptr != $past(rd_ptr)) || (DEPTH == 1));

endmodule

// File: rtl/hpf_almost_flag.sv
module hpf_almost_flag #(
    parameter int DEPTH       = 128,
    parameter int MARGIN      = 8,
    parameter bit TOWARD_FULL = 1'b1,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    output logic          almost
);

    generate
        if (TOWARD_FULL) begin : g_free_side
            localparam logic [CW-1:0] TRIP = CW'(DEPTH - MARGIN);
            assign almost = (count >= TRIP);
            assert_afull_at_full_R6: assert property (@(posedge clk) disable iff (rst)
                (count == CW'(DEPTH)) |-> almost);
        end else begin : g_fill_side
            localparam logic [CW-1:0] TRIP = CW'(MARGIN);
            assign almost = (count <= TRIP);
            assert_aempty_at_empty_R7: assert property (@(posedge clk) disable iff (rst)
                (count == '0) |-> almost);
        end
    endgenerate

endmodule

// File: rtl/hostport_fifo_pair.sv
module hostport_fifo_pair
    import hpf_pkg::*;
#(
    parameter int DEPTH  = HPF_DEPTH,
    parameter int MARGIN = HPF_MARGIN,
    parameter int W      = HPF_WORD_W,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] host_tx_data,
    input  logic         host_tx_push_n,
    output logic         host_tx_full,
    output logic         host_tx_afull,
    output logic [W-1:0] rtr_tx_data,
    output logic         rtr_tx_valid,
    input  logic         rtr_tx_ready,
    input  logic [W-1:0] rtr_rx_data,
    input  logic         rtr_rx_valid,
    output logic         rtr_rx_ready,
    output logic [W-1:0] host_rx_data,
    input  logic         host_rx_pop_n,
    output logic         host_rx_empty,
    output logic         host_rx_aempty
);

    logic [CW-1:0] tx_count, rx_count;
    logic          tx_empty, rx_full;

    hpf_fifo_core #(.W(W), .DEPTH(DEPTH)) u_tx_core (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (!host_tx_push_n),
        .wr_data (host_tx_data),
        .rd_req  (rtr_tx_ready),
        .rd_data (rtr_tx_data),
        .count   (tx_count),
        .full    (host_tx_full),
        .empty   (tx_empty)
    );

    hpf_almost_flag #(.DEPTH(DEPTH), .MARGIN(MARGIN), .TOWARD_FULL(1'b1)) u_tx_flag (
        .clk    (clk),
        .rst    (rst),
        .count  (tx_count),
        .almost (host_tx_afull)
    );

    hpf_fifo_core #(.W(W), .DEPTH(DEPTH)) u_rx_core (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (rtr_rx_valid),
        .wr_data (rtr_rx_data),
        .rd_req  (!host_rx_pop_n),
        .rd_data (host_rx_data),
        .count   (rx_count),
        .full    (rx_full),
        .empty   (host_rx_empty)
    );

    hpf_almost_flag #(.DEPTH(DEPTH), .MARGIN(MARGIN), .TOWARD_FULL(1'b0)) u_rx_flag (
        .clk    (clk),
        .rst    (rst),
        .count  (rx_count),
        .almost (host_rx_aempty)
    );

    assign rtr_tx_valid = !tx_empty;
    assign rtr_rx_ready = !rx_full;

    assert_rx_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
        (rtr_rx_valid && rtr_rx_ready && host_rx_empty && host_rx_pop_n)
            |=> (!host_rx_empty && host_rx_data == $past(rtr_rx_data)));
    assert_no_push_when_high_R2: assert property (@(posedge clk) disable iff (rst)
        (host_tx_push_n && !rtr_tx_valid) |=> !rtr_tx_valid);
    assert_rx_pop_advances_R5: assert property (@(posedge clk) disable iff (rst)
        (!host_rx_pop_n && !host_rx_empty && !rtr_rx_valid && host_rx_aempty)
            |=> host_rx_aempty);

endmodule

// File: tb/hostport_fifo_pair_bench.sv
module hostport_fifo_pair_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int MARGIN     = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] host_tx_data = '0;
    logic       host_tx_push_n = 1'b1;
    logic       host_tx_full, host_tx_afull;
    logic [8:0] rtr_tx_data;
    logic       rtr_tx_valid;
    logic       rtr_tx_ready = 1'b0;
    logic [8:0] rtr_rx_data = '0;
    logic       rtr_rx_valid = 1'b0;
    logic       rtr_rx_ready;
    logic [8:0] host_rx_data;
    logic       host_rx_pop_n = 1'b1;
    logic       host_rx_empty, host_rx_aempty;

    int n_checks = 0;
    int n_fail   = 0;
    int tx_cnt   = 0;
    int rx_cnt   = 0;
    logic [8:0] exp_tx[$];
    logic [8:0] exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostport_fifo_pair u_hostport_fifo_pair (
        .clk(clk), .rst(rst),
        .host_tx_data(host_tx_data), .host_tx_push_n(host_tx_push_n),
        .host_tx_full(host_tx_full), .host_tx_afull(host_tx_afull),
        .rtr_tx_data(rtr_tx_data), .rtr_tx_valid(rtr_tx_valid), .rtr_tx_ready(rtr_tx_ready),
        .rtr_rx_data(rtr_rx_data), .rtr_rx_valid(rtr_rx_valid), .rtr_rx_ready(rtr_rx_ready),
        .host_rx_data(host_rx_data), .host_rx_pop_n(host_rx_pop_n),
        .host_rx_empty(host_rx_empty), .host_rx_aempty(host_rx_aempty)
    );

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: samples handshakes between the driving negedge and the next posedge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (!rst && rtr_tx_valid && rtr_tx_ready) begin
            if (exp_tx.size() == 0) chk("R3 tx unexpected word", rtr_tx_data, 9'h1ff);
            else chk("R3 tx order", rtr_tx_data, exp_tx.pop_front());
        end
        if (!rst && !host_rx_pop_n && !host_rx_empty) begin
            if (exp_rx.size() == 0) chk("R5 rx unexpected pop", host_rx_data, 9'h1ff);
            else chk("R5 rx order", host_rx_data, exp_rx.pop_front());
        end
    end

    // Driver: one clock cycle of stimulus, expected model updated from the requirements.
    task automatic cyc(input logic hp, input logic [8:0] hd, input logic rr,
                       input logic rv, input logic [8:0] rd, input logic pop);
        bit tx_w, tx_r, rx_w, rx_r;
        @(negedge clk);
        host_tx_push_n = !hp; host_tx_data = hd; rtr_tx_ready = rr;
        rtr_rx_valid = rv; rtr_rx_data = rd; host_rx_pop_n = !pop;
        tx_w = hp && tx_cnt < DEPTH;  tx_r = rr && tx_cnt > 0;
        rx_w = rv && rx_cnt < DEPTH;  rx_r = pop && rx_cnt > 0;
        if (tx_w) exp_tx.push_back(hd);
        if (rx_w) exp_rx.push_back(rd);
        tx_cnt += int'(tx_w) - int'(tx_r);
        rx_cnt += int'(rx_w) - int'(rx_r);
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle();
        cyc(0, 9'h0, 0, 0, 9'h0, 0);
    endtask

    task automatic flags(input string tag);
        chk({tag, " R6 tx_full"},   9'(host_tx_full),   9'(tx_cnt == DEPTH));
        chk({tag, " R6 tx_afull"},  9'(host_tx_afull),  9'(tx_cnt >= DEPTH - MARGIN));
        chk({tag, " R6 rx_ready"},  9'(rtr_rx_ready),   9'(rx_cnt != DEPTH));
        chk({tag, " R7 rx_empty"},  9'(host_rx_empty),  9'(rx_cnt == 0));
        chk({tag, " R7 rx_aempty"}, 9'(host_rx_aempty), 9'(rx_cnt <= MARGIN));
        chk({tag, " R1 tx_valid"},  9'(rtr_tx_valid),   9'(tx_cnt != 0));
        if (rx_cnt > 0 && exp_rx.size() > 0)
            chk({tag, " R4 rx head"}, host_rx_data, exp_rx[0]);
    endtask

    task automatic drain_tx();
        while (tx_cnt > 0) cyc(0, 9'h0, 1, 0, 9'h0, 0);
        cyc(0, 9'h0, 1, 0, 9'h0, 0);
    endtask

    task automatic drain_rx();
        while (rx_cnt > 0) cyc(0, 9'h0, 0, 0, 9'h0, 1);
        cyc(0, 9'h0, 0, 0, 9'h0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #(CLK_PERIOD/4);
        flags("R1 reset");

        // R2: strobe high stores nothing
        cyc(0, 9'h0a5, 0, 0, 9'h0, 0);
        flags("R2 push_n high");

        // R3: words and both end codes through the outbound path
        cyc(1, 9'h012, 0, 0, 9'h0, 0);
        cyc(1, 9'h0ff, 0, 0, 9'h0, 0);
        cyc(1, 9'h100, 0, 0, 9'h0, 0);
        cyc(1, 9'h034, 0, 0, 9'h0, 0);
        cyc(1, 9'h101, 0, 0, 9'h0, 0);
        flags("R3 tx loaded");
        drain_tx();
        chk("R3 tx all drained", 9'(exp_tx.size()), 9'd0);

        // R6/R8: fill to the thresholds, then overfill
        for (int i = 0; i < DEPTH - MARGIN - 1; i++) cyc(1, 9'(i), 0, 0, 9'h0, 0);
        flags("R6 119 stored");
        cyc(1, 9'(DEPTH - MARGIN - 1), 0, 0, 9'h0, 0);
        flags("R6 120 stored");
        for (int i = DEPTH - MARGIN; i < DEPTH; i++) cyc(1, 9'(i), 0, 0, 9'h0, 0);
        flags("R6 128 stored");
        cyc(1, 9'h1ee, 0, 0, 9'h0, 0);
        cyc(1, 9'h1dd, 0, 0, 9'h0, 0);
        flags("R8 push while full");
        drain_tx();
        chk("R8 tx contents kept", 9'(exp_tx.size()), 9'd0);
        flags("R8 after drain");

        // R10 on outbound: simultaneous write and read
        cyc(1, 9'h041, 0, 0, 9'h0, 0);
        cyc(1, 9'h042, 0, 0, 9'h0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 9'(9'h050 + i), 1, 0, 9'h0, 0);
        chk("R10 tx count kept", 9'(tx_cnt), 9'd2);
        flags("R10 tx");
        drain_tx();

        // R4: fall-through on inbound path
        cyc(0, 9'h0, 0, 1, 9'h0c3, 0);
        flags("R4 first word");
        chk("R4 head visible", host_rx_data, 9'h0c3);
        cyc(0, 9'h0, 0, 1, 9'h101, 0);
        flags("R4 second word");

        // R7: almost-empty boundary at 8 and 9 words
        for (int i = 2; i < MARGIN; i++) cyc(0, 9'h0, 0, 1, 9'(9'h060 + i), 0);
        flags("R7 8 stored");
        cyc(0, 9'h0, 0, 1, 9'h100, 0);
        flags("R7 9 stored");

        // R10 on inbound, then R5 drain
        for (int i = 0; i < 4; i++) cyc(0, 9'h0, 0, 1, 9'(9'h070 + i), 1);
        chk("R10 rx count kept", 9'(rx_cnt), 9'd9);
        flags("R10 rx");
        drain_rx();
        flags("R5 drained");

        // R9: pop while empty, then next write is the head
        cyc(0, 9'h0, 0, 0, 9'h0, 1);
        cyc(0, 9'h0, 0, 0, 9'h0, 1);
        flags("R9 pop empty");
        cyc(0, 9'h0, 0, 1, 9'h0b7, 0);
        chk("R9 next head", host_rx_data, 9'h0b7);
        flags("R9 after write");

        // R6 inbound full, R8 drop on inbound
        for (int i = 1; i < DEPTH; i++) cyc(0, 9'h0, 0, 1, 9'(i), 0);
        flags("R6 rx full");
        cyc(0, 9'h0, 0, 1, 9'h1aa, 0);
        flags("R8 rx push while full");
        drain_rx();
        chk("R8 rx contents kept", 9'(exp_rx.size()), 9'd0);
        idle();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule